// File: doc/BRIEF.md
# NAND Host Bus Bridge

This block sits between a 16-bit register-mapped host bus and an 8-bit NAND flash device. Software selects the kind of NAND cycle it wants (command, address, data or standby) by writing a byte-wide mode register. The register's bits drive the command-latch, address-latch, chip-enable and write-enable pins directly. The host then moves bytes through a data port, where one 16-bit access becomes two NAND byte cycles.

The bridge generates the read and write strobes with a programmable pulse width. It stalls the host through a wait output and then acknowledges for one cycle when the access is complete.

The ready/busy line from the flash passes through a synchroniser. Its current state can be read from a status register. A rising edge on the line, meaning the flash has finished an operation, latches a ready request in an interrupt status register. That request raises the interrupt output only when its mask bit is set. Software clears the request by writing a one to its bit.

Top module: `nand_bus_bridge`

## Requirements
- R1: After reset the mode register reads 0x00, chip enable is deasserted (`nd_ce_n`=1), CLE, ALE and `nd_wr_en` are low, both strobes are high, and `hb_wait` and `irq` are low.
- R2: The mode register at offset 4 reads back the last byte written to it. Its bits map to pins as follows:
  - Bit 0 drives `nd_cle`, bit 1 drives `nd_ale`, bit 4 asserts chip enable (`nd_ce_n` low) and bit 7 drives `nd_wr_en`.
  - Bits 2, 3, 5 and 6 affect no pin.
  - So 0x94 gives data cycles, 0x95 gives command cycles, 0x96 gives address cycles and 0x00 gives standby with chip enable off.
- R3: A 16-bit write to the data port (offset 0) puts bits 7:0 on `nd_dq_o` for the first `nd_we_n` pulse and bits 15:8 for the second. An 8-bit write makes exactly one pulse, carrying bits 7:0.
- R4: A 16-bit read of the data port makes two `nd_re_n` pulses. The byte sampled during the first pulse is returned in bits 7:0 and the byte from the second in bits 15:8. An 8-bit read makes one pulse and returns that byte in bits 7:0 with bits 15:8 zero.
- R5: Every NAND byte cycle holds its strobe low for exactly STROBE_CLKS clocks and then high for STROBE_CLKS clocks. `nd_we_n` and `nd_re_n` are never low together, and neither is low unless `hb_wait` is high.
- R6: A request is accepted only while `hb_wait` is low. `hb_ack` is high for one cycle:
  - for a register access, in the cycle right after the accepting edge;
  - for a data-port access of B bytes, 2·STROBE_CLKS·B cycles later than that.
  - `hb_wait` is high between acceptance and that acknowledge. Requests made while it is high are ignored.
- R7: The status register at offset 5 reads bit 7 as 1 while `nd_rb` is low (busy). The value is taken after a two-flop synchroniser, and the other bits read 0.
- R8: A rising edge of the synchronised `nd_rb` sets bit 0 of the interrupt status register at offset 6. Writing a 1 to that bit clears it, and the other bits read 0.
- R9: `irq` is high exactly when interrupt status bit 0 and mask bit 0 are both set. The mask register at offset 7 holds and reads back all 8 bits, so writing 0x81 enables the interrupt and writing 0x00 disables it.
- R10: Offsets 1, 2 and 3 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hb_req | input | 1 | Host access request, one cycle |
| hb_we | input | 1 | 1 = write, 0 = read |
| hb_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit |
| hb_addr | input | ADDR_W | Register offset |
| hb_wdata | input | 16 | Write data |
| hb_rdata | output | 16 | Read data, valid with hb_ack |
| hb_ack | output | 1 | Access complete, one cycle |
| hb_wait | output | 1 | Data-port access in progress |
| nd_cle | output | 1 | Command latch enable |
| nd_ale | output | 1 | Address latch enable |
| nd_ce_n | output | 1 | Chip enable, active low |
| nd_wr_en | output | 1 | Write enable level from mode bit 7 |
| nd_we_n | output | 1 | Write strobe, active low |
| nd_re_n | output | 1 | Read strobe, active low |
| nd_dq_o | output | 8 | Byte driven to the flash |
| nd_dq_oe | output | 1 | Output enable for nd_dq_o |
| nd_dq_i | input | 8 | Byte from the flash |
| nd_rb | input | 1 | Ready (1) / busy (0) from the flash |
| irq | output | 1 | Ready interrupt |

## Verification
On every cycle, the assertions check the following:
- the two strobes never overlap;
- strobes appear only inside a stalled access;
- wait always ends with an acknowledge;
- each synchronised ready edge leaves the interrupt status bit set.

Some properties need known stimulus and an independent reference, so only the directed scenarios show them:
- byte order on writes and reads;
- strobe widths;
- exact acknowledge latency;
- the pin effect of each mode value;
- the dropping of requests during a busy access;
- write-1-to-clear and masking.

// File: rtl/nbb_pkg.sv
package nbb_pkg;
  localparam int OFF_DATA  = 0;
  localparam int OFF_MODE  = 4;
  localparam int OFF_STAT  = 5;
  localparam int OFF_ISR   = 6;
  localparam int OFF_MASK  = 7;

  localparam int MODE_CLE_BIT = 0;
  localparam int MODE_ALE_BIT = 1;
  localparam int MODE_CE_BIT  = 4;
  localparam int MODE_WE_BIT  = 7;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_t;

  // Byte lane idx of a 16-bit word; lane 0 goes out/comes in first.
  function automatic logic [7:0] lane_of(input logic [15:0] word, input logic idx);
    return idx ? word[15:8] : word[7:0];
  endfunction

  // Clocks a data-port access keeps the host waiting.
  function automatic int access_clocks(input int strobe_clks, input logic wide);
    return 2 * strobe_clks * (wide ? 2 : 1);
  endfunction
endpackage

// File: rtl/nbb_rb_sync.sv
module nbb_rb_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_async,
  output logic busy,
  output logic rise
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= rb_async;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign busy = !s2_q;
  assign rise = s2_q && !prev_q;
endmodule

// File: rtl/nbb_byte_seq.sv
module nbb_byte_seq
  import nbb_pkg::*;
#(
  parameter int STROBE_CLKS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        wr,
  input  logic        wide,
  input  logic [15:0] wdata,
  input  logic [7:0]  dq_i,
  output logic        active,
  output logic        last_tick,
  output logic [15:0] rdata,
  output logic        we_n,
  output logic        re_n,
  output logic [7:0]  dq_o,
  output logic        dq_oe
);
  localparam int CW = (STROBE_CLKS > 1) ? $clog2(STROBE_CLKS) : 1;
  localparam logic [CW-1:0] CNT_MAX = CW'(STROBE_CLKS - 1);

  phase_t        phase_q;
  logic [CW-1:0] cnt_q;
  logic          idx_q;
  logic          wr_q, wide_q;
  logic [15:0]   wdata_q;
  logic [15:0]   rbuf_q;
  logic          phase_end;

  assign phase_end = (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      idx_q   <= 1'b0;
      wr_q    <= 1'b0;
      wide_q  <= 1'b0;
      wdata_q <= '0;
      rbuf_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q <= PH_LOW;
            cnt_q   <= '0;
            idx_q   <= 1'b0;
            wr_q    <= wr;
            wide_q  <= wide;
            wdata_q <= wdata;
            rbuf_q  <= '0;
          end
        end
        PH_LOW: begin
          if (phase_end) begin
            if (!wr_q) begin
              if (idx_q) rbuf_q[15:8] <= dq_i;
              else       rbuf_q[7:0]  <= dq_i;
            end
            phase_q <= PH_HIGH;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_HIGH: begin
          if (phase_end) begin
            cnt_q <= '0;
            if (idx_q == wide_q) begin
              phase_q <= PH_IDLE;
            end else begin
              phase_q <= PH_LOW;
              idx_q   <= 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign active    = (phase_q != PH_IDLE);
  assign last_tick = (phase_q == PH_HIGH) && phase_end && (idx_q == wide_q);
  assign rdata     = rbuf_q;
  assign we_n      = !((phase_q == PH_LOW) && wr_q);
  assign re_n      = !((phase_q == PH_LOW) && !wr_q);
  assign dq_o      = lane_of(wdata_q, idx_q);
  assign dq_oe     = active && wr_q;
endmodule

// File: rtl/nbb_irq.sv
module nbb_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rise,
  input  logic       isr_we,
  input  logic       mask_we,
  input  logic [7:0] wdata,
  output logic       isr_q,
  output logic [7:0] mask_q,
  output logic       irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q  <= 1'b0;
      mask_q <= '0;
    end else begin
      if (rise)                     isr_q <= 1'b1;
      else if (isr_we && wdata[0])  isr_q <= 1'b0;
      if (mask_we) mask_q <= wdata;
    end
  end

  assign irq = isr_q && mask_q[0];
endmodule

// File: rtl/nand_bus_bridge.sv
module nand_bus_bridge
  import nbb_pkg::*;
#(
  parameter int STROBE_CLKS = 3,
  parameter int ADDR_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hb_req,
  input  logic              hb_we,
  input  logic              hb_wide,
  input  logic [ADDR_W-1:0] hb_addr,
  input  logic [15:0]       hb_wdata,
  output logic [15:0]       hb_rdata,
  output logic              hb_ack,
  output logic              hb_wait,
  output logic              nd_cle,
  output logic              nd_ale,
  output logic              nd_ce_n,
  output logic              nd_wr_en,
  output logic              nd_we_n,
  output logic              nd_re_n,
  output logic [7:0]        nd_dq_o,
  output logic              nd_dq_oe,
  input  logic [7:0]        nd_dq_i,
  input  logic              nd_rb,
  output logic              irq
);
  logic        accept, sel_data, sel_mode, sel_stat, sel_isr, sel_mask;
  logic        reg_acc;
  logic        seq_active, seq_last;
  logic [15:0] seq_rdata;
  logic        rb_busy, rdy_rise;
  logic        isr_q;
  logic [7:0]  mask_q;
  logic [7:0]  mode_q;
  logic [7:0]  reg_rd;

  assign accept   = hb_req && !seq_active;
  assign sel_data = (hb_addr == ADDR_W'(OFF_DATA));
  assign sel_mode = (hb_addr == ADDR_W'(OFF_MODE));
  assign sel_stat = (hb_addr == ADDR_W'(OFF_STAT));
  assign sel_isr  = (hb_addr == ADDR_W'(OFF_ISR));
  assign sel_mask = (hb_addr == ADDR_W'(OFF_MASK));
  assign reg_acc  = accept && !sel_data;

  nbb_rb_sync u_sync (
    .clk(clk), .rst_n(rst_n), .rb_async(nd_rb),
    .busy(rb_busy), .rise(rdy_rise)
  );

  nbb_byte_seq #(.STROBE_CLKS(STROBE_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(accept && sel_data), .wr(hb_we), .wide(hb_wide),
    .wdata(hb_wdata), .dq_i(nd_dq_i),
    .active(seq_active), .last_tick(seq_last), .rdata(seq_rdata),
    .we_n(nd_we_n), .re_n(nd_re_n), .dq_o(nd_dq_o), .dq_oe(nd_dq_oe)
  );

  nbb_irq u_irq (
    .clk(clk), .rst_n(rst_n), .rise(rdy_rise),
    .isr_we(reg_acc && hb_we && sel_isr),
    .mask_we(reg_acc && hb_we && sel_mask),
    .wdata(hb_wdata[7:0]),
    .isr_q(isr_q), .mask_q(mask_q), .irq(irq)
  );

  always_comb begin
    reg_rd = '0;
    if (sel_mode) reg_rd = mode_q;
    if (sel_stat) reg_rd = {rb_busy, 7'b0};
    if (sel_isr)  reg_rd = {7'b0, isr_q};
    if (sel_mask) reg_rd = mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      hb_ack   <= 1'b0;
      hb_rdata <= '0;
    end else begin
      hb_ack <= reg_acc || seq_last;
      if (reg_acc && hb_we && sel_mode) mode_q <= hb_wdata[7:0];
      if (reg_acc)       hb_rdata <= hb_we ? 16'h0 : {8'h00, reg_rd};
      else if (seq_last) hb_rdata <= seq_rdata;
    end
  end

  assign hb_wait  = seq_active;
  assign nd_cle   = mode_q[MODE_CLE_BIT];
  assign nd_ale   = mode_q[MODE_ALE_BIT];
  assign nd_ce_n  = !mode_q[MODE_CE_BIT];
  assign nd_wr_en = mode_q[MODE_WE_BIT];
endmodule

// File: rtl/nbb_checker.sv
module nbb_checker (
  input logic clk,
  input logic rst_n,
  input logic hb_wait,
  input logic hb_ack,
  input logic nd_we_n,
  input logic nd_re_n,
  input logic rdy_rise,
  input logic isr_bit
);
  a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nd_we_n && !nd_re_n));

  a_r5_strobe_inside_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (!nd_we_n || !nd_re_n) |-> hb_wait);

  a_r6_wait_ends_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hb_wait) |-> hb_ack);

  a_r8_edge_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_rise |=> isr_bit);
endmodule

bind nand_bus_bridge nbb_checker i_nbb_checker (
  .clk(clk), .rst_n(rst_n), .hb_wait(hb_wait), .hb_ack(hb_ack),
  .nd_we_n(nd_we_n), .nd_re_n(nd_re_n),
  .rdy_rise(rdy_rise), .isr_bit(isr_q)
);

// File: tb/test_nand_bus_bridge.sv
module test_nand_bus_bridge;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hb_req = 1'b0, hb_we = 1'b0, hb_wide = 1'b0;
  logic [2:0]  hb_addr = '0;
  logic [15:0] hb_wdata = '0;
  logic [15:0] hb_rdata;
  logic hb_ack, hb_wait, nd_cle, nd_ale, nd_ce_n, nd_wr_en, nd_we_n, nd_re_n, nd_dq_oe, irq;
  logic [7:0] nd_dq_o;
  logic [7:0] nd_dq_i = '0;
  logic nd_rb = 1'b1;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  nand_bus_bridge #(.STROBE_CLKS(N), .ADDR_W(3)) i_nand_bus_bridge (
    .clk(clk), .rst_n(rst_n), .hb_req(hb_req), .hb_we(hb_we), .hb_wide(hb_wide),
    .hb_addr(hb_addr), .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .hb_ack(hb_ack),
    .hb_wait(hb_wait), .nd_cle(nd_cle), .nd_ale(nd_ale), .nd_ce_n(nd_ce_n),
    .nd_wr_en(nd_wr_en), .nd_we_n(nd_we_n), .nd_re_n(nd_re_n), .nd_dq_o(nd_dq_o),
    .nd_dq_oe(nd_dq_oe), .nd_dq_i(nd_dq_i), .nd_rb(nd_rb), .irq(irq)
  );

  // strobe monitor, sampled on falling clock edges
  logic [7:0] wb [0:7];
  int ww [0:7];
  int rw [0:7];
  logic wcle [0:7];
  logic wale [0:7];
  int wcount = 0, rcount = 0, cur_w = 0, cur_r = 0;
  logic prev_we = 1'b1, prev_re = 1'b1;

  always @(negedge clk) begin
    if (!nd_we_n) begin
      if (prev_we) cur_w = 0;
      cur_w++;
      if (wcount < 8) begin
        wb[wcount] = nd_dq_o; wcle[wcount] = nd_cle; wale[wcount] = nd_ale;
      end
    end else if (!prev_we) begin
      if (wcount < 8) ww[wcount] = cur_w;
      wcount++;
    end
    if (!nd_re_n) begin
      if (prev_re) cur_r = 0;
      cur_r++;
    end else if (!prev_re) begin
      if (rcount < 8) rw[rcount] = cur_r;
      rcount++;
    end
    prev_we = nd_we_n;
    prev_re = nd_re_n;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic host(input logic we, input logic wide, input logic [2:0] addr,
                      input logic [15:0] wd, output logic [15:0] rd, output int cyc);
    @(negedge clk);
    hb_req = 1'b1; hb_we = we; hb_wide = wide; hb_addr = addr; hb_wdata = wd;
    cyc = 0;
    @(negedge clk);
    hb_req = 1'b0;
    cyc = 1;
    while (!hb_ack) begin
      @(negedge clk);
      cyc++;
    end
    rd = hb_rdata;
  endtask

  function automatic int exp_data_cyc(input logic wide);
    return 2 * N * (wide ? 2 : 1) + 1;
  endfunction

  task automatic t_reset();
    chk("R1 mode pins", {nd_ce_n, nd_cle, nd_ale, nd_wr_en}, 4'b1000);
    chk("R1 strobes", {nd_we_n, nd_re_n, hb_wait, irq}, 4'b1100);
  endtask

  task automatic t_modes();
    logic [15:0] rd; int c;
    host(1, 0, 3'd4, 16'h0095, rd, c);
    chk("R6 register ack latency", c, 1);
    chk("R2 cmd mode pins", {nd_ce_n, nd_cle, nd_ale, nd_wr_en}, 4'b0101);
    host(1, 0, 3'd4, 16'h0096, rd, c);
    chk("R2 addr mode pins", {nd_ce_n, nd_cle, nd_ale, nd_wr_en}, 4'b0011);
    host(1, 0, 3'd4, 16'h006C, rd, c);
    chk("R2 spare bits no pin effect", {nd_ce_n, nd_cle, nd_ale, nd_wr_en}, 4'b1000);
    host(0, 0, 3'd4, 16'h0, rd, c);
    chk("R2 mode readback", rd, 16'h006C);
    host(1, 0, 3'd4, 16'h0000, rd, c);
    chk("R2 standby pins", {nd_ce_n, nd_cle, nd_ale, nd_wr_en}, 4'b1000);
  endtask

  task automatic t_writes();
    logic [15:0] rd; int c;
    host(1, 0, 3'd4, 16'h0095, rd, c);
    wcount = 0;
    host(1, 0, 3'd0, 16'hAA70, rd, c);
    chk("R3 8-bit write count", wcount, 1);
    chk("R3 8-bit write byte", wb[0], 8'h70);
    chk("R2 CLE during command byte", wcle[0], 1'b1);
    chk("R6 8-bit data ack latency", c, exp_data_cyc(0));
    host(1, 0, 3'd4, 16'h0096, rd, c);
    wcount = 0;
    host(1, 1, 3'd0, 16'h3412, rd, c);
    chk("R3 16-bit write count", wcount, 2);
    chk("R3 first byte low lane", wb[0], 8'h12);
    chk("R3 second byte high lane", wb[1], 8'h34);
    chk("R2 ALE during address bytes", {wale[0], wale[1]}, 2'b11);
    chk("R5 write low width", ww[0], N);
    chk("R5 write low width 2", ww[1], N);
    chk("R6 16-bit data ack latency", c, exp_data_cyc(1));
  endtask

  task automatic t_reads();
    logic [15:0] rd; int c;
    host(1, 0, 3'd4, 16'h0094, rd, c);
    rcount = 0;
    fork
      host(0, 1, 3'd0, 16'h0, rd, c);
      begin
        nd_dq_i = 8'hC3;
        @(posedge nd_re_n);
        nd_dq_i = 8'h5A;
      end
    join
    chk("R4 16-bit read order", rd, 16'h5AC3);
    chk("R4 16-bit read pulses", rcount, 2);
    chk("R5 read low width", rw[1], N);
    nd_dq_i = 8'hE7;
    rcount = 0;
    host(0, 0, 3'd0, 16'h0, rd, c);
    chk("R4 8-bit read", rd, 16'h00E7);
    chk("R4 8-bit read pulses", rcount, 1);
  endtask

  task automatic t_ignore_busy();
    logic [15:0] rd; int c;
    wcount = 0;
    fork
      host(1, 1, 3'd0, 16'hBEEF, rd, c);
      begin
        repeat (4) @(negedge clk);
        hb_req = 1'b1; hb_we = 1'b1; hb_addr = 3'd4; hb_wdata = 16'h0000; hb_wide = 1'b0;
        @(negedge clk);
        hb_req = 1'b0; hb_addr = 3'd0; hb_wide = 1'b1; hb_wdata = 16'hBEEF;
      end
    join
    chk("R6 busy access bytes", wcount, 2);
    host(0, 0, 3'd4, 16'h0, rd, c);
    chk("R6 request during wait ignored", rd, 16'h0094);
  endtask

  task automatic t_status_irq();
    logic [15:0] rd; int c;
    nd_rb = 1'b0;
    repeat (4) @(negedge clk);
    host(0, 0, 3'd5, 16'h0, rd, c);
    chk("R7 busy status", rd, 16'h0080);
    nd_rb = 1'b1;
    repeat (5) @(negedge clk);
    host(0, 0, 3'd5, 16'h0, rd, c);
    chk("R7 ready status", rd, 16'h0000);
    host(0, 0, 3'd6, 16'h0, rd, c);
    chk("R8 ready request latched", rd, 16'h0001);
    chk("R9 masked irq low", irq, 1'b0);
    host(1, 0, 3'd7, 16'h0081, rd, c);
    chk("R9 irq with mask", irq, 1'b1);
    host(0, 0, 3'd7, 16'h0, rd, c);
    chk("R9 mask readback", rd, 16'h0081);
    host(1, 0, 3'd6, 16'h000E, rd, c);
    chk("R8 write 0 to bit0 keeps", irq, 1'b1);
    host(1, 0, 3'd6, 16'h000F, rd, c);
    chk("R8 write-1-to-clear", irq, 1'b0);
    host(0, 0, 3'd6, 16'h0, rd, c);
    chk("R8 status cleared", rd, 16'h0000);
    nd_rb = 1'b0;
    repeat (4) @(negedge clk);
    nd_rb = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 irq on second edge", irq, 1'b1);
    host(1, 0, 3'd7, 16'h0000, rd, c);
    chk("R9 disabled mask drops irq", irq, 1'b0);
    host(1, 0, 3'd6, 16'h0001, rd, c);
  endtask

  task automatic t_unmapped();
    logic [15:0] rd; int c;
    for (int a = 1; a < 4; a++) begin
      host(1, 0, 3'(a), 16'h00FF, rd, c);
      host(0, 0, 3'(a), 16'h0, rd, c);
      chk("R10 unmapped reads zero", rd, 16'h0000);
    end
    host(0, 0, 3'd4, 16'h0, rd, c);
    chk("R10 mode untouched", rd, 16'h0094);
    host(0, 0, 3'd7, 16'h0, rd, c);
    chk("R10 mask untouched", rd, 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_writes();
    t_reads();
    t_ignore_busy();
    t_status_irq();
    t_unmapped();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule